// File: doc/BRIEF.md
# PCIe Wake and PME Event Collector

This block merges the wake signals of several PCI Express ports into a single platform wake request. Each port drives an active-low wake pin. The block synchronises each pin into the local clock domain and detects its falling edge. While the platform is asleep, it turns any edge on an enabled pin into a one-cycle wake request pulse. Each pin has its own disable bit. A pin event never leaves a status trace of its own.

The block also keeps a sticky status bit for power-management event messages. Upstream logic decodes those messages and delivers a one-cycle pulse for each one. The pulse sets the bit. Software clears it by writing a one, which reaches the block as a one-cycle clear strobe. If the pulse and the clear arrive in the same cycle, the pulse wins. The sleep state machine lives elsewhere. It supplies a single level that is high in any sleep state and low in the working state.

Top module: `pcie_wake_collector`

## Requirements
- R1: Each wake pin is active low, with 1 = idle and 0 = wake. A high-to-low transition on pin n, sampled at rising edge k, makes `wake_req` high for exactly one cycle after rising edge k+2. This holds when the pin is enabled and the platform is asleep at edge k+2.
- R2: A pin held low after its falling edge produces no further pulses. A new pulse needs the pin to return high and fall again.
- R3: `sleep_active` = 1 means a sleep state (S3, S4 or S5) and 0 means the working state. When `sleep_active` is 0 at the edge where the pulse would appear, wake pin activity produces no `wake_req`.
- R4: `wake_dis[n]` = 1 stops pin n from causing a wake. Pins whose bit is 0 still cause a wake.
- R5: Falling edges on several enabled pins in the same cycle produce a single one-cycle `wake_req` pulse.
- R6: A one-cycle `pme_rcvd` pulse sets `pme_sts` at the next rising edge. The bit then stays set until it is cleared.
- R7: `pme_clr` high with `pme_rcvd` low clears `pme_sts` at the next rising edge.
- R8: When `pme_rcvd` and `pme_clr` are high in the same cycle, `pme_sts` is 1 after that edge.
- R9: Wake pin activity never changes `pme_sts`.
- R10: After a synchronous active-low reset, `wake_req` and `pme_sts` are 0. The pin synchronisers reset to the idle (high) level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wake_pin_n | input | 4 | Active-low wake pins, one per port, asynchronous |
| wake_dis | input | 4 | Per-pin wake disable, 1 = disabled |
| pme_rcvd | input | 1 | One-cycle pulse: PME message received |
| sleep_active | input | 1 | 1 = platform in a sleep state |
| pme_clr | input | 1 | Write-one-to-clear strobe for the PME status bit |
| wake_req | output | 1 | One-cycle platform wake request |
| pme_sts | output | 1 | Sticky PME status bit |

## Verification
Wake trials draw a random sleep level, a random disable mask and a random set of falling pins. Each trial counts the resulting pulses and times the first one. This separates the sleep gate from the per-pin gate, and single-pin edges from simultaneous ones. Directed trials cover a pin held low for a long time, a pin that is disabled while other pins stay enabled, and activity while awake. The status bit is driven with random pulse and clear strobes. Their collisions show whether set beats clear. Wake pins toggle during this sequence, which shows that pin events never disturb the status bit.

// File: rtl/pwc_pkg.sv
// Package: shared constants for the PCIe wake and PME event collector.
// Assumes: consumers take their widths from their own parameters; these are defaults.
package pwc_pkg;
    localparam int unsigned DEF_PORTS       = 4;
    localparam int unsigned DEF_SYNC_STAGES = 2;
    // Electrical meaning of the wake pin level.
    typedef enum logic {
        PIN_ACTIVE = 1'b0,
        PIN_IDLE   = 1'b1
    } pin_level_e;
endpackage

// File: rtl/wake_edge_detect.sv
// Module: wake_edge_detect
// Brings one asynchronous active-low wake pin into the clock domain through
// SYNC_STAGES flip-flops, then flags a one-cycle falling edge.
// Assumes: SYNC_STAGES >= 2; the pin is idle (high) while in reset.
module wake_edge_detect
    import pwc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [LAST:0] chain;
    logic          prev;
    logic          synced;

    assign synced = chain[LAST];

    // Shift the pin through the synchroniser chain; reset to idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {SYNC_STAGES{PIN_IDLE}};
        end else begin
            chain <= {chain[LAST-1:0], pin_n};
        end
    end

    // Hold the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= PIN_IDLE;
        end else begin
            prev <= synced;
        end
    end

    // Falling edge: was idle, now active.
    assign fall = (prev == PIN_IDLE) && (synced == PIN_ACTIVE);

    // R2
    fall_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/wake_combiner.sv
// Module: wake_combiner
// Masks per-pin falling edges with their disable bits, ORs them and gates
// the result with the sleep indicator into a registered one-cycle request.
// Assumes: edge inputs are single-cycle pulses in the clk domain.
module wake_combiner #(
    parameter int unsigned NUM_PORTS = pwc_pkg::DEF_PORTS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] edge_seen,
    input  logic [NUM_PORTS-1:0] pin_dis,
    input  logic                 asleep,
    output logic                 req
);
    logic [NUM_PORTS-1:0] live;
    logic                 any_live;

    // Drop edges from disabled pins, then reduce to a single flag.
    always_comb begin
        live     = edge_seen & ~pin_dis;
        any_live = |live;
    end

    // Register the request; only while asleep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
        end else begin
            req <= any_live && asleep;
        end
    end

    // R3
    wake_only_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !asleep |=> !req);
    // R4
    all_disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&pin_dis) |=> !req);
endmodule

// File: rtl/pme_status_reg.sv
// Module: pme_status_reg
// Sticky status bit set by a PME-received pulse and cleared by a
// write-one-to-clear strobe; a set in the same cycle as a clear wins.
// Assumes: both inputs are synchronous single-cycle strobes.
module pme_status_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic clr_strobe,
    output logic sts
);
    // Update the sticky bit with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= 1'b0;
        end else if (set_pulse) begin
            sts <= 1'b1;
        end else if (clr_strobe) begin
            sts <= 1'b0;
        end
    end

    // R6
    set_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> sts);
    // R7
    clear_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_strobe && !set_pulse) |=> !sts);
    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_strobe && !set_pulse) |=> $stable(sts));
endmodule

// File: rtl/pcie_wake_collector.sv
// Module: pcie_wake_collector (top)
// Collects active-low wake pins from NUM_PORTS PCI Express ports into one
// wake request during sleep, and keeps a sticky PME status bit.
// Assumes: wake pins are asynchronous; all other inputs are synchronous to clk.
module pcie_wake_collector
    import pwc_pkg::*;
#(
    parameter int unsigned NUM_PORTS   = DEF_PORTS,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] wake_pin_n,
    input  logic [NUM_PORTS-1:0] wake_dis,
    input  logic                 pme_rcvd,
    input  logic                 sleep_active,
    input  logic                 pme_clr,
    output logic                 wake_req,
    output logic                 pme_sts
);
    logic [NUM_PORTS-1:0] pin_fall;

    // One synchroniser and edge detector per port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        wake_edge_detect #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .pin_n(wake_pin_n[p]),
            .fall (pin_fall[p])
        );
    end

    wake_combiner #(
        .NUM_PORTS(NUM_PORTS)
    ) u_comb (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_seen(pin_fall),
        .pin_dis  (wake_dis),
        .asleep   (sleep_active),
        .req      (wake_req)
    );

    pme_status_reg u_pme (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (pme_rcvd),
        .clr_strobe(pme_clr),
        .sts       (pme_sts)
    );

    // R10
    reset_outputs_low_chk: assert property (@(posedge clk)
        !rst_n |=> (!wake_req && !pme_sts));
    // R9
    pins_leave_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pme_rcvd && !pme_clr) |=> $stable(pme_sts));
endmodule

// File: tb/pcie_wake_collector_test.sv
`timescale 1ns/1ps
module pcie_wake_collector_test;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] wake_pin_n;
    logic [NP-1:0] wake_dis;
    logic          pme_rcvd;
    logic          sleep_active;
    logic          pme_clr;
    logic          wake_req;
    logic          pme_sts;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    pcie_wake_collector uut (
        .clk(clk), .rst_n(rst_n), .wake_pin_n(wake_pin_n), .wake_dis(wake_dis),
        .pme_rcvd(pme_rcvd), .sleep_active(sleep_active), .pme_clr(pme_clr),
        .wake_req(wake_req), .pme_sts(pme_sts)
    );

    // Expected pulse count for one trial (R3, R4, R5).
    function automatic int exp_pulses(bit slp, logic [NP-1:0] dis, logic [NP-1:0] drop);
        return (slp && ((drop & ~dis) != 0)) ? 1 : 0;
    endfunction

    // Expected next status bit (R6, R7, R8).
    function automatic bit exp_sts(bit cur, bit set, bit clr);
        if (set) return 1'b1;
        if (clr) return 1'b0;
        return cur;
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Return all pins to idle, then drop a set of pins.
    // Count pulses in a window; the first pulse is expected at index 3.
    task automatic wake_trial(bit slp, logic [NP-1:0] dis, logic [NP-1:0] drop,
                              int hold, string tag);
        int cnt   = 0;
        int first = -1;
        @(negedge clk);
        wake_pin_n   = '1;
        sleep_active = slp;
        wake_dis     = dis;
        repeat (5) @(negedge clk);
        wake_pin_n = ~drop;
        for (int i = 1; i <= hold; i++) begin
            @(negedge clk);
            if (wake_req) begin
                cnt++;
                if (first < 0) first = i;
            end
        end
        check(cnt == exp_pulses(slp, dis, drop), {tag, " count"}, cnt, exp_pulses(slp, dis, drop));
        if (exp_pulses(slp, dis, drop) == 1)
            check(first == 3, {tag, " R1 timing"}, first, 3);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit model;
        void'($urandom(32'h5eed_1234));
        rst_n = 0; wake_pin_n = '1; wake_dis = '0; pme_rcvd = 0;
        sleep_active = 0; pme_clr = 0;
        repeat (4) @(negedge clk);
        // R10 reset state
        check(wake_req == 0, "R10 wake_req reset", wake_req, 0);
        check(pme_sts == 0, "R10 pme_sts reset", pme_sts, 0);
        rst_n = 1;
        @(negedge clk);

        // Directed wake trials
        wake_trial(1, 4'b0000, 4'b0001, 8,  "R1 single pin");
        wake_trial(1, 4'b0000, 4'b0100, 40, "R2 held low");
        wake_trial(0, 4'b0000, 4'b1111, 8,  "R3 awake");
        wake_trial(1, 4'b0010, 4'b0010, 8,  "R4 disabled pin");
        wake_trial(1, 4'b0010, 4'b1000, 8,  "R4 other pin enabled");
        wake_trial(1, 4'b0000, 4'b1111, 8,  "R5 all pins together");
        check(pme_sts == 0, "R9 pins leave pme_sts", pme_sts, 0);

        // Random wake trials
        for (int t = 0; t < 40; t++) begin
            wake_trial(bit'($urandom_range(0, 1)), 4'($urandom), 4'($urandom), 8, "R3/R4/R5 random");
        end

        // Directed PME corner cases
        model = pme_sts;
        @(negedge clk); pme_rcvd = 1; @(negedge clk); pme_rcvd = 0;
        check(pme_sts == 1, "R6 set", pme_sts, 1);
        repeat (5) @(negedge clk);
        check(pme_sts == 1, "R6 sticky", pme_sts, 1);
        pme_rcvd = 1; pme_clr = 1; @(negedge clk); pme_rcvd = 0; pme_clr = 0;
        check(pme_sts == 1, "R8 set beats clear", pme_sts, 1);
        pme_clr = 1; @(negedge clk); pme_clr = 0;
        check(pme_sts == 0, "R7 clear", pme_sts, 0);

        // Random PME strobes with wake pin noise (R6, R7, R8, R9)
        model = 0;
        for (int c = 0; c < 300; c++) begin
            bit s = ($urandom_range(0, 7) == 0);
            bit k = ($urandom_range(0, 5) == 0);
            model        = exp_sts(model, s, k);
            pme_rcvd     = s;
            pme_clr      = k;
            wake_pin_n   = 4'($urandom);
            sleep_active = bit'($urandom_range(0, 1));
            @(negedge clk);
            check(pme_sts == model, "R6/R7/R8/R9 random pme", pme_sts, model);
        end
        pme_rcvd = 0; pme_clr = 0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule